// File: doc/BRIEF.md
# Low-Power Wakeup Source Controller

This block collects wakeup requests from up to three external pins, from a radio-busy status line and from a supply-voltage detector. It turns each qualifying edge into a sticky pending flag. It then tells the power sequencer and the CPU which of those flags count in the current power mode (Run, Stop, Standby or Shutdown). Each source may act only from its own subset of modes. The voltage-detector source listens only while the radio reports that it is active.

Software programs two registers through a simple synchronous register port. One register holds the per-source enables and the other selects the active edge for each source. A third address shows the pending flags and clears them with write-one-to-clear. All three registers use the same bit positions: pin n at bit n, the voltage detector at bit 8 and the radio-busy source at bit 11. Every asynchronous input is resynchronized before its edge is detected. Both the wakeup request and the interrupt are registered outputs.

Top module: `wkup_src_ctrl`

## Requirements
- R1: Synchronous active-high reset clears both control registers and all flags, and drives `wake_o`, `irq_o` and `flags_o` low.
- R2: The enable register (address 0) keeps only bits 0..NPIN-1 (pin enables), bit 8 (voltage detector) and bit 11 (radio busy). Every other bit, including bits 3 to 6, ignores writes and reads 0, so writing 0xFFFF reads back 0x0907.
- R3: The polarity register (address 1) keeps only bits 0..NPIN-1 (pin edge) and bit 11 (radio edge), where 0 selects the rising edge and 1 the falling edge. All other bits read 0, so writing 0xFFFF reads back 0x0807.
- R4: An edge of the selected polarity on an enabled pin sets its flag. A disabled pin, or an edge of the other direction, sets nothing. `flags_o` is packed as pins at bits 0..NPIN-1, radio at bit NPIN and voltage detector at bit NPIN+1. Address 2 reads the same flags at register bit positions (pin n at bit n, 8 and 11).
- R5: A pending pin flag raises `wake_o` in Stop, Standby and Shutdown, and raises `irq_o` in every mode.
- R6: A pending radio-busy flag raises `wake_o` only in Standby and never raises `irq_o`. Its active edge follows polarity bit 11.
- R7: The voltage-detector flag is set by a rising edge of `vdet_below_i` only while enable bit 8 is set and `radio_active_i` is high. A pending voltage-detector flag raises `wake_o` in Stop and Standby, and raises `irq_o` in Run, Stop and Standby but not in Shutdown.
- R8: Writing ones to address 2 clears the matching flags and leaves the other flags unchanged.
- R9: Changing a polarity bit while the input is steady never sets a flag.
- R10: In Run mode (`pmode_i` = 0) `wake_o` stays low whatever flags are pending. The mode codes are Stop = 1, Standby = 2 and Shutdown = 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NPIN | Raw wakeup pin levels (asynchronous) |
| radio_busy_i | input | 1 | Radio busy status (asynchronous) |
| radio_active_i | input | 1 | Radio active state (asynchronous) |
| vdet_below_i | input | 1 | Supply below threshold flag (asynchronous) |
| pmode_i | input | 2 | Current power mode: 0 Run, 1 Stop, 2 Standby, 3 Shutdown |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 enable, 1 polarity, 2 flags |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Registered read data of the addressed register |
| wake_o | output | 1 | Wakeup request to the power sequencer |
| irq_o | output | 1 | Interrupt to the CPU |
| flags_o | output | NPIN+2 | Sticky pending flags, packed |

## Verification
The bench builds the block with its defaults, NPIN = 3 and DW = 16, so every source and every mode fits in a full sweep. Each pin is swept over all combinations of enable, polarity and edge direction. Each source's flag is then raised on its own, and all flags together, and checked in all four power modes against a table computed in the bench. This covers every cell of the mode-permission matrix, including the radio-active gate on the voltage detector and a polarity flip under a steady input.

// File: rtl/wkup_pkg.sv
package wkup_pkg;
  typedef enum logic [1:0] {
    PM_RUN      = 2'd0,
    PM_STOP     = 2'd1,
    PM_STANDBY  = 2'd2,
    PM_SHUTDOWN = 2'd3
  } pmode_e;

  typedef enum logic [1:0] {
    SRC_PIN   = 2'd0,
    SRC_RADIO = 2'd1,
    SRC_VDET  = 2'd2
  } src_kind_e;

  localparam int VDET_BIT  = 8;
  localparam int RADIO_BIT = 11;

  localparam logic [1:0] ADDR_EN   = 2'd0;
  localparam logic [1:0] ADDR_POL  = 2'd1;
  localparam logic [1:0] ADDR_FLAG = 2'd2;

  function automatic logic may_wake(input logic [1:0] mode, input src_kind_e kind);
    case (kind)
      SRC_PIN:   may_wake = (mode != PM_RUN);
      SRC_RADIO: may_wake = (mode == PM_STANDBY);
      default:   may_wake = (mode == PM_STOP) || (mode == PM_STANDBY);
    endcase
  endfunction

  function automatic logic may_irq(input logic [1:0] mode, input src_kind_e kind);
    case (kind)
      SRC_PIN:   may_irq = 1'b1;
      SRC_RADIO: may_irq = 1'b0;
      default:   may_irq = (mode != PM_SHUTDOWN);
    endcase
  endfunction
endpackage

// File: rtl/wkup_sync.sv
module wkup_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/wkup_edge.sv
module wkup_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  input  logic pol_i,
  output logic edge_o
);
  logic hist_q;
  logic pol_q;
  logic lvl_eff;

  // Polarity folded into the level: a falling input becomes a rising lvl_eff.
  assign lvl_eff = lvl_i ^ pol_i;

  // History is refreshed every cycle with the new polarity; a polarity
  // change masks the detector for that cycle so the fold cannot fake an edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= 1'b0;
      pol_q  <= 1'b0;
    end else begin
      hist_q <= lvl_eff;
      pol_q  <= pol_i;
    end
  end

  assign edge_o = (pol_i == pol_q) && lvl_eff && !hist_q;
endmodule

// File: rtl/wkup_regs.sv
module wkup_regs
  import wkup_pkg::*;
#(
  parameter int NPIN = 3,
  parameter int DW   = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_i,
  input  logic [1:0]      addr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [NPIN+1:0] set_i,
  output logic [DW-1:0]   en_o,
  output logic [DW-1:0]   pol_o,
  output logic [NPIN+1:0] flags_o,
  output logic [DW-1:0]   rdata_o
);
  localparam int NS         = NPIN + 2;
  localparam int PIN_MASK_I = (1 << NPIN) - 1;
  localparam int EN_MASK_I  = PIN_MASK_I | (1 << VDET_BIT) | (1 << RADIO_BIT);
  localparam int POL_MASK_I = PIN_MASK_I | (1 << RADIO_BIT);
  localparam logic [DW-1:0] EN_MASK  = EN_MASK_I[DW-1:0];
  localparam logic [DW-1:0] POL_MASK = POL_MASK_I[DW-1:0];

  logic [DW-1:0] en_q, pol_q;
  logic [NS-1:0] flag_q;
  logic [NS-1:0] clr;
  logic [DW-1:0] flag_view;

  // Register bit layout -> packed flag order {vdet, radio, pins}.
  assign clr = (wr_i && addr_i == ADDR_FLAG)
             ? {wdata_i[VDET_BIT], wdata_i[RADIO_BIT], wdata_i[NPIN-1:0]}
             : '0;

  always_comb begin
    flag_view            = '0;
    flag_view[NPIN-1:0]  = flag_q[NPIN-1:0];
    flag_view[RADIO_BIT] = flag_q[NPIN];
    flag_view[VDET_BIT]  = flag_q[NPIN+1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= '0;
      pol_q   <= '0;
      flag_q  <= '0;
      rdata_o <= '0;
    end else begin
      if (wr_i && addr_i == ADDR_EN)  en_q  <= wdata_i & EN_MASK;
      if (wr_i && addr_i == ADDR_POL) pol_q <= wdata_i & POL_MASK;
      flag_q <= (flag_q & ~clr) | set_i;
      case (addr_i)
        ADDR_EN:   rdata_o <= en_q;
        ADDR_POL:  rdata_o <= pol_q;
        ADDR_FLAG: rdata_o <= flag_view;
        default:   rdata_o <= '0;
      endcase
    end
  end

  assign en_o    = en_q;
  assign pol_o   = pol_q;
  assign flags_o = flag_q;
endmodule

// File: rtl/wkup_route.sv
module wkup_route
  import wkup_pkg::*;
#(
  parameter int NPIN = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      mode_i,
  input  logic [NPIN+1:0] flags_i,
  output logic            wake_o,
  output logic            irq_o
);
  localparam int NS = NPIN + 2;

  logic [NS-1:0] wake_mask, irq_mask;

  for (genvar s = 0; s < NS; s++) begin : g_mask
    localparam src_kind_e KIND = (s < NPIN) ? SRC_PIN :
                                 (s == NPIN) ? SRC_RADIO : SRC_VDET;
    assign wake_mask[s] = may_wake(mode_i, KIND);
    assign irq_mask[s]  = may_irq(mode_i, KIND);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wake_o <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      wake_o <= |(flags_i & wake_mask);
      irq_o  <= |(flags_i & irq_mask);
    end
  end
endmodule

// File: rtl/wkup_src_ctrl.sv
module wkup_src_ctrl
  import wkup_pkg::*;
#(
  parameter int NPIN = 3,
  parameter int DW   = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] pin_i,
  input  logic            radio_busy_i,
  input  logic            radio_active_i,
  input  logic            vdet_below_i,
  input  logic [1:0]      pmode_i,
  input  logic            reg_wr_i,
  input  logic [1:0]      reg_addr_i,
  input  logic [DW-1:0]   reg_wdata_i,
  output logic [DW-1:0]   reg_rdata_o,
  output logic            wake_o,
  output logic            irq_o,
  output logic [NPIN+1:0] flags_o
);
  localparam int NS   = NPIN + 2;
  localparam int SYNW = NPIN + 3;

  logic [SYNW-1:0] raw, syn;
  logic [NS-1:0]   lvl, pol_sel, edges, en_src, set_vec;
  logic [DW-1:0]   en_q, pol_q;
  logic            active_s;

  assign raw = {radio_active_i, vdet_below_i, radio_busy_i, pin_i};

  wkup_sync #(.W(SYNW), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .d_i(raw), .q_o(syn)
  );

  assign active_s = syn[NPIN+2];
  assign lvl      = syn[NPIN+1:0];
  assign pol_sel  = {1'b0, pol_q[RADIO_BIT], pol_q[NPIN-1:0]};
  assign en_src   = {en_q[VDET_BIT] & active_s, en_q[RADIO_BIT], en_q[NPIN-1:0]};

  for (genvar s = 0; s < NS; s++) begin : g_edge
    wkup_edge u_edge (
      .clk(clk), .rst(rst), .lvl_i(lvl[s]), .pol_i(pol_sel[s]), .edge_o(edges[s])
    );
  end

  assign set_vec = edges & en_src;

  wkup_regs #(.NPIN(NPIN), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .set_i(set_vec), .en_o(en_q), .pol_o(pol_q),
    .flags_o(flags_o), .rdata_o(reg_rdata_o)
  );

  wkup_route #(.NPIN(NPIN)) u_route (
    .clk(clk), .rst(rst), .mode_i(pmode_i), .flags_i(flags_o),
    .wake_o(wake_o), .irq_o(irq_o)
  );
endmodule

// File: rtl/wkup_src_ctrl_chk.sv
module wkup_src_ctrl_chk #(
  parameter int NPIN = 3,
  parameter int DW   = 16
) (
  input logic            clk,
  input logic            rst,
  input logic [1:0]      pmode_i,
  input logic [NPIN+1:0] flags_o,
  input logic [NPIN+1:0] en_src,
  input logic [DW-1:0]   reg_rdata_o,
  input logic            wake_o,
  input logic            irq_o
);
  localparam int NS = NPIN + 2;
  localparam logic [NS-1:0] NONRADIO = ~(NS'(1) << NPIN);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (flags_o == '0 && !wake_o && !irq_o));

  a_r10_run_no_wake: assert property (@(posedge clk) disable iff (rst)
    $past(pmode_i) == 2'd0 |-> !wake_o);

  a_r6_radio_no_irq: assert property (@(posedge clk) disable iff (rst)
    ($past(flags_o & NONRADIO) == '0) |-> !irq_o);

  a_r6_radio_standby_only: assert property (@(posedge clk) disable iff (rst)
    ($past(pmode_i) != 2'd2 && $past(flags_o & NONRADIO) == '0) |-> !wake_o);

  a_r4_flag_needs_enable: assert property (@(posedge clk) disable iff (rst)
    ((flags_o & ~$past(flags_o)) & ~$past(en_src)) == '0);

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    reg_rdata_o[6:3] == 4'd0);
endmodule

bind wkup_src_ctrl wkup_src_ctrl_chk #(.NPIN(NPIN), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .pmode_i(pmode_i), .flags_o(flags_o), .en_src(en_src),
  .reg_rdata_o(reg_rdata_o), .wake_o(wake_o), .irq_o(irq_o)
);

// File: tb/sim_wkup_src_ctrl.sv
module sim_wkup_src_ctrl;
  localparam int NPIN = 3;
  localparam int DW   = 16;
  localparam int NS   = NPIN + 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rst = 1'b1;
  logic [NPIN-1:0] pin = '0;
  logic            busy = 1'b0, active = 1'b0, below = 1'b0;
  logic [1:0]      pmode = 2'd0;
  logic            reg_wr = 1'b0;
  logic [1:0]      reg_addr = 2'd0;
  logic [DW-1:0]   reg_wdata = '0;
  logic [DW-1:0]   reg_rdata;
  logic            wake, irq;
  logic [NS-1:0]   flags;

  wkup_src_ctrl #(.NPIN(NPIN), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .pin_i(pin), .radio_busy_i(busy),
    .radio_active_i(active), .vdet_below_i(below), .pmode_i(pmode),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .wake_o(wake), .irq_o(irq), .flags_o(flags)
  );

  int  n_cmp = 0, n_bad = 0;
  bit  done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
    reg_addr = a;
    cyc(2);
    d = reg_rdata;
  endtask

  function automatic logic exp_wake(input logic [1:0] m, input logic [NS-1:0] f);
    logic p = |f[NPIN-1:0];
    case (m)
      2'd0: return 1'b0;
      2'd1: return p | f[NPIN+1];
      2'd2: return p | f[NPIN] | f[NPIN+1];
      default: return p;
    endcase
  endfunction

  function automatic logic exp_irq(input logic [1:0] m, input logic [NS-1:0] f);
    logic p = |f[NPIN-1:0];
    return (m == 2'd3) ? p : (p | f[NPIN+1]);
  endfunction

  // Raise exactly one flag: s < NPIN pin, s == NPIN radio, s == NPIN+1 detector.
  task automatic make_flag(input int s);
    if (s < NPIN) begin
      wr(2'd0, DW'(1) << s); wr(2'd1, '0);
      pin[s] = 1'b1; cyc(6);
      wr(2'd0, '0); pin[s] = 1'b0; cyc(6);
    end else if (s == NPIN) begin
      wr(2'd0, DW'(1) << 11); wr(2'd1, '0);
      busy = 1'b1; cyc(6);
      wr(2'd0, '0); busy = 1'b0; cyc(6);
    end else begin
      active = 1'b1; wr(2'd0, DW'(1) << 8); cyc(4);
      below = 1'b1; cyc(6);
      wr(2'd0, '0); below = 1'b0; active = 1'b0; cyc(6);
    end
  endtask

  task automatic mode_sweep(input logic [NS-1:0] f, input string tag);
    for (int m = 0; m < 4; m++) begin
      pmode = 2'(m);
      cyc(3);
      chk({tag, " wake R5/R6/R7/R10"}, 32'(wake), 32'(exp_wake(2'(m), f)));
      chk({tag, " irq R5/R6/R7"}, 32'(irq), 32'(exp_irq(2'(m), f)));
    end
    pmode = 2'd0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    logic exp_set;
    cyc(3);
    rst = 1'b0;
    cyc(1);
    // R1 reset state
    chk("R1 flags", 32'(flags), 0);
    chk("R1 wake", 32'(wake), 0);
    chk("R1 irq", 32'(irq), 0);
    rd(2'd0, d); chk("R1 en reg", 32'(d), 0);
    rd(2'd1, d); chk("R1 pol reg", 32'(d), 0);

    // R2 enable register mask
    wr(2'd0, 16'hFFFF); rd(2'd0, d); chk("R2 en all ones", 32'(d), 32'h0907);
    wr(2'd0, 16'h0078); rd(2'd0, d); chk("R2 reserved only", 32'(d), 0);
    // R3 polarity register mask
    wr(2'd1, 16'hFFFF); rd(2'd1, d); chk("R3 pol all ones", 32'(d), 32'h0807);
    wr(2'd1, 16'h0000); wr(2'd0, 16'h0000); cyc(6);

    // R4 sweep: pin x enable x polarity x direction
    for (int p = 0; p < NPIN; p++)
      for (int en = 0; en < 2; en++)
        for (int pl = 0; pl < 2; pl++)
          for (int dir = 0; dir < 2; dir++) begin
            pin[p] = (dir == 1);
            wr(2'd1, DW'(pl) << p);
            wr(2'd0, DW'(en) << p);
            cyc(6);
            wr(2'd2, 16'hFFFF); cyc(2);
            pin[p] = ~pin[p];
            cyc(6);
            exp_set = (en == 1) && (pl == dir);
            chk("R4 flags_o", 32'(flags), 32'(exp_set) << p);
            rd(2'd2, d); chk("R4 flag reg", 32'(d), 32'(exp_set) << p);
            wr(2'd0, '0); pin[p] = 1'b0; cyc(6);
            wr(2'd1, '0); cyc(4);
            wr(2'd2, 16'hFFFF); cyc(2);
          end

    // R6 radio falling-edge polarity
    busy = 1'b1; wr(2'd1, 16'h0800); wr(2'd0, 16'h0800); cyc(6);
    wr(2'd2, 16'hFFFF); cyc(2);
    busy = 1'b0; cyc(6);
    chk("R6 radio falling", 32'(flags), 32'(1) << NPIN);
    rd(2'd2, d); chk("R6 radio flag reg bit 11", 32'(d), 32'h0800);
    wr(2'd0, '0); wr(2'd1, '0); cyc(4); wr(2'd2, 16'hFFFF); cyc(2);

    // R7 detector gating
    wr(2'd0, 16'h0100); active = 1'b0; cyc(4);
    below = 1'b1; cyc(6);
    chk("R7 inactive radio blocks", 32'(flags), 0);
    below = 1'b0; wr(2'd0, '0); active = 1'b1; cyc(6);
    below = 1'b1; cyc(6);
    chk("R7 disabled blocks", 32'(flags), 0);
    below = 1'b0; active = 1'b0; cyc(6);
    make_flag(NPIN + 1);
    rd(2'd2, d); chk("R7 flag reg bit 8", 32'(d), 32'h0100);
    wr(2'd2, 16'hFFFF); cyc(2);

    // R5/R6/R7/R10 mode matrix, each source alone then all together
    for (int s = 0; s < NS; s++) begin
      make_flag(s);
      chk("R4 single flag", 32'(flags), 32'(1) << s);
      mode_sweep(NS'(1) << s, "single");
      wr(2'd2, 16'hFFFF); cyc(3);
      chk("R8 cleared", 32'(flags), 0);
    end
    for (int s = 0; s < NS; s++) make_flag(s);
    mode_sweep('1, "all");

    // R8 selective clear
    wr(2'd2, 16'h0001); cyc(2);
    chk("R8 clear pin0 only", 32'(flags), 32'h1E);
    wr(2'd2, 16'h0800); cyc(2);
    chk("R8 clear radio only", 32'(flags), 32'h16);
    wr(2'd2, 16'hFFFF); cyc(2);

    // R9 polarity flip under steady input
    pin[0] = 1'b0; wr(2'd0, 16'h0001); cyc(6);
    wr(2'd1, 16'h0001); cyc(6);
    chk("R9 flip to falling", 32'(flags), 0);
    wr(2'd1, 16'h0000); cyc(6);
    chk("R9 flip to rising", 32'(flags), 0);
    wr(2'd1, 16'h0001); cyc(4);
    pin[0] = 1'b1; cyc(6);
    chk("R9 rising ignored when falling", 32'(flags), 0);
    pin[0] = 1'b0; cyc(6);
    chk("R9 falling detected", 32'(flags), 1);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule